// File: doc/BRIEF.md
# Link Resynchronization Attention Controller

This controller supervises the receive side of a point-to-point bit-mirroring link. Upstream logic decodes each incoming message and passes on a one-cycle message strobe, an error flag, a flag saying whether the message is an attention message, and the identifier that such a message carries. From these the controller keeps a receive-OK status and tells the local transmitter whether to send ordinary data messages or attention messages stamped with the local identifier.

The controller drops receive-OK on any erroneous message. When enough erroneous messages arrive in a row, it enters an attention loop. In that loop it keeps requesting attention messages until an error-free attention message comes back carrying an identifier equal to the local one. That is the proof that the far end is hearing this node. The controller then pulses a synchronization strobe and returns to data transfer. Receive-OK comes back with the first clean data message after that.

Top module: `link_resync_ctrl`

## Requirements
- R1: While `rst_n` is low, `rx_ok`, `tx_attn` and `sync_done` are 0 and `tx_id` is 0.
- R2: A message with `msg_valid`=1 and `msg_err`=1 makes `rx_ok` 0 in the cycle after that message's clock edge.
- R3: `ERR_LIMIT` (default 2) erroneous messages with no error-free message between them set `tx_attn` to 1 in the cycle after the last one. Cycles with `msg_valid`=0 between them do not break the run.
- R4: Outside the attention loop, any error-free message, data or attention, restarts the count of consecutive errors. One error followed by a clean message therefore does not enter the loop.
- R5: While `tx_attn` is 1, `tx_id` equals `local_id` and `rx_ok` is 0. While `tx_attn` is 0, `tx_id` is 0.
- R6: The loop is left only on an error-free message with `msg_attn`=1 and `msg_id`==`local_id`. Data messages, erroneous messages and attention messages with any other ID keep `tx_attn` at 1 for any number of messages.
- R7: On leaving the loop, `sync_done` is 1 for exactly one cycle, in the cycle after the matching message, together with `tx_attn` falling to 0.
- R8: Outside the loop, `rx_ok` becomes 1 in the cycle after an error-free data message (`msg_attn`=0). An error-free attention message leaves `rx_ok` unchanged.
- R9: Inputs presented with `msg_valid`=0 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| local_id | input | ID_W | Programmed local transmit identifier |
| msg_valid | input | 1 | One-cycle strobe: a received message has been decoded |
| msg_err | input | 1 | The strobed message failed its checks |
| msg_attn | input | 1 | The strobed message is an attention message |
| msg_id | input | ID_W | Identifier carried by a received attention message |
| rx_ok | output | 1 | Receive link healthy |
| tx_attn | output | 1 | Transmitter must send attention messages |
| tx_id | output | ID_W | Identifier to place in outgoing attention messages |
| sync_done | output | 1 | One-cycle strobe: synchronization achieved |

## Verification
All results are registered once, so each output reflects a message one clock edge after that message's strobe is sampled. The bench applies every stimulus at a falling edge and holds it across exactly one rising edge. It samples every output at the following falling edge, before the next stimulus goes on. `tx_id` follows `tx_attn` with no extra delay and is checked in the same sample. Vectors check `sync_done` in the cycle of the exit and again one cycle later, to confirm that the pulse is exactly one cycle wide.

// File: rtl/link_resync_pkg.sv
package link_resync_pkg;
  typedef enum logic {
    ST_LINK = 1'b0,
    ST_ATTN = 1'b1
  } lr_state_e;
endpackage

// File: rtl/lr_err_counter.sv
module lr_err_counter #(
  parameter int ERR_LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic clr,
  output logic limit_hit
);
  localparam int CNT_W = $clog2(ERR_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ERR_LIMIT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign limit_hit = inc && (cnt_q == LAST);

  always_comb begin
    cnt_en = inc || clr;
    cnt_d  = cnt_q;
    if (clr || limit_hit) cnt_d = '0;
    else if (inc)         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R3: the run length never reaches the limit while stored
  a_r3_cnt_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(ERR_LIMIT));
  // R4: a clear empties the run
  a_r4_clr_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);
endmodule

// File: rtl/lr_id_match.sv
module lr_id_match #(
  parameter int ID_W = 8
) (
  input  logic            attn_flag,
  input  logic [ID_W-1:0] rx_id,
  input  logic [ID_W-1:0] own_id,
  output logic            match
);
  assign match = attn_flag && (rx_id == own_id);
endmodule

// File: rtl/link_resync_ctrl.sv
module link_resync_ctrl
  import link_resync_pkg::*;
#(
  parameter int ID_W      = 8,
  parameter int ERR_LIMIT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ID_W-1:0] local_id,
  input  logic            msg_valid,
  input  logic            msg_err,
  input  logic            msg_attn,
  input  logic [ID_W-1:0] msg_id,
  output logic            rx_ok,
  output logic            tx_attn,
  output logic [ID_W-1:0] tx_id,
  output logic            sync_done
);
  lr_state_e state_q, state_d;
  logic      ok_q, ok_d, sync_q, sync_d;
  logic      bad_msg, good_msg, in_link, run_inc, run_clr, run_hit, id_hit;

  assign bad_msg  = msg_valid && msg_err;
  assign good_msg = msg_valid && !msg_err;
  assign in_link  = (state_q == ST_LINK);
  assign run_inc  = in_link && bad_msg;
  assign run_clr  = (in_link && good_msg) || !in_link;

  lr_err_counter #(.ERR_LIMIT(ERR_LIMIT)) u_run (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc       (run_inc),
    .clr       (run_clr),
    .limit_hit (run_hit)
  );

  lr_id_match #(.ID_W(ID_W)) u_match (
    .attn_flag (msg_attn),
    .rx_id     (msg_id),
    .own_id    (local_id),
    .match     (id_hit)
  );

  always_comb begin
    state_d = state_q;
    ok_d    = ok_q;
    sync_d  = 1'b0;
    unique case (state_q)
      ST_LINK: begin
        if (bad_msg) begin
          ok_d = 1'b0;
          if (run_hit) state_d = ST_ATTN;
        end else if (good_msg && !msg_attn) begin
          ok_d = 1'b1;
        end
      end
      ST_ATTN: begin
        ok_d = 1'b0;
        if (good_msg && id_hit) begin
          state_d = ST_LINK;
          sync_d  = 1'b1;
        end
      end
      default: state_d = ST_LINK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_LINK;
      ok_q    <= 1'b0;
      sync_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ok_q    <= ok_d;
      sync_q  <= sync_d;
    end
  end

  assign rx_ok     = ok_q;
  assign tx_attn   = (state_q == ST_ATTN);
  assign sync_done = sync_q;
  assign tx_id     = tx_attn ? local_id : '0;

  a_r2_err_drops_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_err) |=> !rx_ok);
  a_r3_attn_entry_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_attn) |-> $past(msg_valid && msg_err));
  a_r5_attn_no_ok: assert property (@(posedge clk) disable iff (!rst_n)
    tx_attn |-> !rx_ok);
  a_r6_exit_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_attn) |-> $past(msg_valid && !msg_err && msg_attn && msg_id == local_id));
  a_r7_sync_single: assert property (@(posedge clk) disable iff (!rst_n)
    sync_done |=> !sync_done);
  a_r7_sync_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
    sync_done |-> (!tx_attn && $past(tx_attn)));
  a_r8_ok_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ok) |-> $past(msg_valid && !msg_err && !msg_attn));
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid |=> ($stable(rx_ok) && $stable(tx_attn)));
endmodule

// File: tb/link_resync_ctrl_tb_top.sv
`timescale 1ns/1ps
module link_resync_ctrl_tb_top;
  localparam logic [7:0] LID = 8'h5A;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       msg_valid, msg_err, msg_attn;
  logic [7:0] msg_id, tx_id;
  logic       rx_ok, tx_attn, sync_done;
  int         n_chk = 0;
  int         n_fail = 0;

  always #2.5 clk = ~clk;

  link_resync_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .local_id(LID),
    .msg_valid(msg_valid), .msg_err(msg_err), .msg_attn(msg_attn), .msg_id(msg_id),
    .rx_ok(rx_ok), .tx_attn(tx_attn), .tx_id(tx_id), .sync_done(sync_done)
  );

  // {valid, err, attn, id[7:0], exp_ok, exp_attn, exp_sync}
  localparam int NV = 19;
  localparam logic [13:0] VEC [NV] = '{
    {3'b100, 8'h00, 3'b100},  // R8 clean data sets ok
    {3'b110, 8'h00, 3'b000},  // R2 error drops ok
    {3'b100, 8'h00, 3'b100},  // R4 clean data breaks run
    {3'b110, 8'h00, 3'b000},  // R2
    {3'b011, 8'h5A, 3'b000},  // R9 idle, not counted as clean
    {3'b110, 8'h00, 3'b010},  // R3 second error enters loop
    {3'b100, 8'h00, 3'b010},  // R6 data keeps loop
    {3'b101, 8'h5B, 3'b010},  // R6 wrong id keeps loop
    {3'b111, 8'h5A, 3'b010},  // R6 erroneous match keeps loop
    {3'b101, 8'h5A, 3'b001},  // R7 match exits with strobe
    {3'b000, 8'h00, 3'b000},  // R7 strobe one cycle
    {3'b101, 8'h5A, 3'b000},  // R8 attn msg leaves ok
    {3'b100, 8'h00, 3'b100},  // R8 data sets ok
    {3'b110, 8'h00, 3'b000},  // R2
    {3'b101, 8'h33, 3'b000},  // R4 attn msg clears run, ok unchanged
    {3'b110, 8'h00, 3'b000},  // R4 only first of new run
    {3'b110, 8'h00, 3'b010},  // R3
    {3'b001, 8'h5A, 3'b010},  // R9 idle match ignored
    {3'b101, 8'h5A, 3'b001}   // R7
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(input logic v, input logic e, input logic a, input logic [7:0] id);
    msg_valid = v; msg_err = e; msg_attn = a; msg_id = id;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_outs(input string req, input logic ok, input logic at, input logic s);
    check({req, " rx_ok"}, {7'd0, rx_ok}, {7'd0, ok});
    check({req, " tx_attn"}, {7'd0, tx_attn}, {7'd0, at});
    check({req, " sync_done"}, {7'd0, sync_done}, {7'd0, s});
    check({req, " tx_id"}, tx_id, at ? LID : 8'h00);
  endtask

  initial begin
    #1000000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    msg_valid = 1'b0; msg_err = 1'b0; msg_attn = 1'b0; msg_id = 8'h00;
    repeat (3) @(negedge clk);
    check_outs("R1 reset", 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      put(VEC[i][13], VEC[i][12], VEC[i][11], VEC[i][10:3]);
      check_outs($sformatf("R2-R9 vector %0d", i), VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R6: long loop with mismatched ids never exits
    put(1'b1, 1'b1, 1'b0, 8'h00);
    put(1'b1, 1'b1, 1'b0, 8'h00);
    check_outs("R3 re-entry", 1'b0, 1'b1, 1'b0);
    for (int k = 0; k < 60; k++) begin
      put(1'b1, 1'b0, 1'b1, 8'(k) ^ 8'hA5);
      if (tx_attn !== 1'b1 || sync_done !== 1'b0)
        check("R6 long loop", {6'd0, tx_attn, sync_done}, 8'h02);
    end
    check_outs("R6 after long loop", 1'b0, 1'b1, 1'b0);

    // R1: asynchronous reset in the middle of the loop
    msg_valid = 1'b0;
    #1 rst_n = 1'b0;
    #1 check_outs("R1 reset in loop", 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    put(1'b1, 1'b1, 1'b0, 8'h00);
    check_outs("R4 single error after reset", 1'b0, 1'b0, 1'b0);
    put(1'b1, 1'b0, 1'b0, 8'h00);
    check_outs("R8 recovery", 1'b1, 1'b0, 1'b0);
    put(1'b0, 1'b0, 1'b0, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule